// File: doc/BRIEF.md
# Segment Offset Translation and Access Checker

This block takes one memory access per cycle, expressed as an offset into a segment, and works out the flat 32-bit address together with a verdict on whether the access is legal for that segment. The segment's attributes come from a descriptor that was already fetched and cached: base, a 20-bit limit, a byte/page granularity flag, a big flag, a code/data flag, a combined writable-or-readable flag, a downward-growth flag and a present flag. The request carries the offset, the access length, the access kind and whether the stack segment register was used.

The block answers one clock cycle after it samples a request. A two-state machine tracks whether a response is on the outputs. `ST_IDLE` means no response is showing. `ST_RESP` means a registered response is showing. The transition `IDLE->RESP` (and `RESP->RESP`) happens on any edge that samples `req_valid` high. The transition `RESP->IDLE` (and `IDLE->IDLE`) happens on any edge that samples it low.

Top module: `seg_xlate_chk`

## Requirements
- R1: When an access raises no fault, `lin_addr` equals `desc_base + req_offset` modulo 2^32 in the response cycle.
- R2: `rsp_valid` is high in exactly the cycle after an edge that sampled `req_valid` high, and low otherwise. `rsp_fault` uses the codes 00 none, 01 stack fault and 10 general-protection fault, and it reads 00 whenever `rsp_valid` is low.
- R3: With `desc_gran` = 0 and the segment growing upward, every byte from `req_offset` to `req_offset + req_len_m1` must lie in 0..`desc_limit`, or the access faults.
- R4: With `desc_gran` = 1, the effective limit is `desc_limit`*4096 + 4095, and it is used in place of the raw limit in every bound check.
- R5: A data segment with `desc_expdown` = 1 accepts offsets strictly above the effective limit, up to 0xFFFF_FFFF when `desc_big` = 1 or up to 0xFFFF otherwise. `desc_expdown` has no effect on code segments (`desc_code` = 1).
- R6: An access whose first byte is in range but whose last byte is out of range faults. An upward segment access whose last byte would pass 0xFFFF_FFFF also faults.
- R7: A not-present descriptor (`desc_present` = 0) yields 01 if `req_stack` = 1 and 10 otherwise. This takes priority over every other check.
- R8: A bound violation on a present segment with no type misuse yields 01 when `req_stack` = 1 and 10 otherwise.
- R9: Kind encoding is 00 read, 01 write, 10 fetch, 11 reserved. Each of the following yields 10, and this check ranks above the bound check: writing a code segment, reading a code segment whose `desc_wr_rd` = 0, fetching from a data segment, writing a data segment whose `desc_wr_rd` = 0, or any reserved kind.
- R10: After reset and before any request, `rsp_valid` is 0 and `rsp_fault` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_offset | input | 32 | Segment-relative offset of first byte |
| req_len_m1 | input | 2 | Access length in bytes minus one |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 reserved |
| req_stack | input | 1 | Access goes through the stack segment |
| desc_base | input | 32 | Segment base |
| desc_limit | input | 20 | Raw segment limit |
| desc_gran | input | 1 | Limit counts 4 KB units when set |
| desc_big | input | 1 | Selects the 32-bit upper bound for downward segments |
| desc_code | input | 1 | Segment is code (1) or data (0) |
| desc_wr_rd | input | 1 | Data: writable; code: readable |
| desc_expdown | input | 1 | Data segment grows downward |
| desc_present | input | 1 | Descriptor present |
| lin_addr | output | 32 | Linear address; don't-care when a fault is reported |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_fault | output | 2 | Fault code |

## Verification
Every result appears one register stage after the request: the edge that samples `req_valid` loads the address and the fault code, and both can be read until the next edge. The bench changes inputs on the falling edge, lets one rising edge pass, and compares `rsp_valid`, `rsp_fault` and `lin_addr` on the following falling edge. It then drives the next request in that same instant, so back-to-back requests are checked each in its own response cycle. After the sweep, an idle cycle confirms that the strobe drops and the fault code returns to 00 one edge after `req_valid` goes low.

// File: rtl/segx_pkg.sv
package segx_pkg;
    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_STACK = 2'b01,
        FLT_GP    = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/seg_bound_calc.sv
module seg_bound_calc #(
    parameter int ADDR_W      = 32,
    parameter int LIM_W       = 20,
    parameter int GRAN_SHIFT  = 12,
    parameter int LEN_W       = 2,
    parameter int SMALL_TOP_W = 16
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic [LIM_W-1:0]  limit,
    input  logic              gran,
    input  logic              grows_down,
    input  logic              big,
    output logic              limit_bad
);
    localparam int SPAN_W = ADDR_W + 1;

    logic [ADDR_W-1:0] eff_lim;
    logic [SPAN_W-1:0] first_b;
    logic [SPAN_W-1:0] last_b;
    logic [SPAN_W-1:0] top_dn;
    logic              up_bad;
    logic              dn_bad;

    always_comb begin
        if (gran) begin
            eff_lim = ADDR_W'({limit, {GRAN_SHIFT{1'b1}}});
        end else begin
            eff_lim = ADDR_W'(limit);
        end
        first_b = {1'b0, offset};
        last_b  = first_b + SPAN_W'(len_m1);
        top_dn  = big ? {1'b0, {ADDR_W{1'b1}}} : SPAN_W'({SMALL_TOP_W{1'b1}});
        up_bad  = last_b > {1'b0, eff_lim};
        dn_bad  = (first_b <= {1'b0, eff_lim}) || (last_b > top_dn);
        limit_bad = grows_down ? dn_bad : up_bad;
    end
endmodule

// File: rtl/seg_type_chk.sv
module seg_type_chk
    import segx_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       is_code,
    input  logic       wr_rd,
    output logic       type_bad
);
    always_comb begin
        unique case (acc_e'(kind))
            ACC_READ:  type_bad = is_code & ~wr_rd;
            ACC_WRITE: type_bad = is_code | ~wr_rd;
            ACC_FETCH: type_bad = ~is_code;
            ACC_RSVD:  type_bad = 1'b1;
            default:   type_bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import segx_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LIM_W       = 20,
    parameter int GRAN_SHIFT  = 12,
    parameter int LEN_W       = 2,
    parameter int SMALL_TOP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [LEN_W-1:0]  req_len_m1,
    input  logic [1:0]        req_kind,
    input  logic              req_stack,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic [LIM_W-1:0]  desc_limit,
    input  logic              desc_gran,
    input  logic              desc_big,
    input  logic              desc_code,
    input  logic              desc_wr_rd,
    input  logic              desc_expdown,
    input  logic              desc_present,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_fault
);
    rsp_state_e        state_q, state_d;
    fault_e            fault_d, fault_q;
    logic [ADDR_W-1:0] addr_q;
    logic              limit_bad;
    logic              type_bad;
    logic              grows_down;

    assign grows_down = desc_expdown & ~desc_code;

    seg_bound_calc #(
        .ADDR_W(ADDR_W), .LIM_W(LIM_W), .GRAN_SHIFT(GRAN_SHIFT),
        .LEN_W(LEN_W), .SMALL_TOP_W(SMALL_TOP_W)
    ) bound_i (
        .offset(req_offset), .len_m1(req_len_m1), .limit(desc_limit),
        .gran(desc_gran), .grows_down(grows_down), .big(desc_big),
        .limit_bad(limit_bad)
    );

    seg_type_chk type_i (
        .kind(req_kind), .is_code(desc_code), .wr_rd(desc_wr_rd),
        .type_bad(type_bad)
    );

    // Fault ranking: presence, then type, then bounds.
    always_comb begin
        if (!desc_present) begin
            fault_d = req_stack ? FLT_STACK : FLT_GP;
        end else if (type_bad) begin
            fault_d = FLT_GP;
        end else if (limit_bad) begin
            fault_d = req_stack ? FLT_STACK : FLT_GP;
        end else begin
            fault_d = FLT_NONE;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            fault_q <= FLT_NONE;
        end else if (req_valid) begin
            addr_q  <= desc_base + req_offset;
            fault_q <= fault_d;
        end
    end

    always_comb begin
        rsp_valid = (state_q == ST_RESP);
        rsp_fault = (state_q == ST_RESP) ? fault_q : FLT_NONE;
        lin_addr  = addr_q;
    end

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);  // R2
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_fault == 2'b00));  // R2
    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != 2'b11);  // R2
    AST_ADDR_IS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault != 2'b00 || lin_addr == $past(desc_base + req_offset)));  // R1
    AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !desc_present) |=> rsp_fault == ($past(req_stack) ? 2'b01 : 2'b10));  // R7
    AST_STACK_CLASS_ONLY_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_stack) |=> rsp_fault != 2'b01);  // R8
    AST_FETCH_DATA_GP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && desc_present && !desc_code && req_kind == 2'b10) |=> rsp_fault == 2'b10);  // R9
endmodule

// File: tb/seg_xlate_chk_tb_top.sv
module seg_xlate_chk_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_offset;
    logic [1:0]  req_len_m1;
    logic [1:0]  req_kind;
    logic        req_stack;
    logic [31:0] desc_base;
    logic [19:0] desc_limit;
    logic        desc_gran, desc_big, desc_code, desc_wr_rd, desc_expdown, desc_present;
    logic [31:0] lin_addr;
    logic        rsp_valid;
    logic [1:0]  rsp_fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seg_xlate_chk dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
        .req_len_m1(req_len_m1), .req_kind(req_kind), .req_stack(req_stack),
        .desc_base(desc_base), .desc_limit(desc_limit), .desc_gran(desc_gran),
        .desc_big(desc_big), .desc_code(desc_code), .desc_wr_rd(desc_wr_rd),
        .desc_expdown(desc_expdown), .desc_present(desc_present),
        .lin_addr(lin_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault)
    );

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_fault(
        input logic [31:0] off, input logic [1:0] len, input logic [19:0] lim,
        input bit g, input bit ed, input bit big, input bit code, input bit wr,
        input bit pres, input bit stk, input logic [1:0] kind);
        longint unsigned eff, last, top;
        bit lim_bad, ty_bad;
        eff  = g ? (longint'(lim) * 4096 + 4095) : longint'(lim);
        last = longint'(off) + longint'(len);
        if (ed && !code) begin
            top = big ? 64'hFFFF_FFFF : 64'hFFFF;
            lim_bad = (longint'(off) <= eff) || (last > top);
        end else begin
            lim_bad = last > eff;
        end
        case (kind)
            2'b00:   ty_bad = code && !wr;
            2'b01:   ty_bad = code || !wr;
            2'b10:   ty_bad = !code;
            default: ty_bad = 1'b1;
        endcase
        if (!pres) return stk ? 2'b01 : 2'b10;
        if (ty_bad) return 2'b10;
        if (lim_bad) return stk ? 2'b01 : 2'b10;
        return 2'b00;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [19:0] lims [4];
        logic [1:0]  ef;
        logic [31:0] eff32;
        lims[0] = 20'h00000; lims[1] = 20'h00005; lims[2] = 20'h0FFFF; lims[3] = 20'hFFFFF;
        rst_n = 1'b0; req_valid = 1'b0; req_offset = '0; req_len_m1 = '0; req_kind = '0;
        req_stack = 1'b0; desc_base = '0; desc_limit = '0; desc_gran = 1'b0; desc_big = 1'b0;
        desc_code = 1'b0; desc_wr_rd = 1'b0; desc_expdown = 1'b0; desc_present = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset rsp_valid", rsp_valid, 0);
        check("R10 reset rsp_fault", rsp_fault, 0);

        // Sweep: R3 R4 R5 R6 R7 R8 R9 fault class, R1 address, R2 strobe.
        for (int li = 0; li < 4; li++)
        for (int g = 0; g < 2; g++)
        for (int ed = 0; ed < 2; ed++)
        for (int bg = 0; bg < 2; bg++)
        for (int cd = 0; cd < 2; cd++)
        for (int wr = 0; wr < 2; wr++)
        for (int pr = 0; pr < 2; pr++)
        for (int st = 0; st < 2; st++)
        for (int kd = 0; kd < 4; kd++)
        for (int ln = 0; ln < 4; ln++)
        for (int oi = 0; oi < 6; oi++) begin
            eff32 = g ? {lims[li], 12'hFFF} : {12'h000, lims[li]};
            case (oi)
                0: req_offset = eff32 - 32'(ln);
                1: req_offset = eff32 - 32'(ln) + 32'd1;
                2: req_offset = eff32;
                3: req_offset = eff32 + 32'd1;
                4: req_offset = 32'h0;
                default: req_offset = 32'hFFFF_FFFE - 32'(ln);
            endcase
            desc_limit = lims[li]; desc_gran = g[0]; desc_expdown = ed[0];
            desc_big = bg[0]; desc_code = cd[0]; desc_wr_rd = wr[0];
            desc_present = pr[0]; req_stack = st[0]; req_kind = kd[1:0];
            req_len_m1 = ln[1:0];
            desc_base = 32'hFFFF_0000 | (32'(li) << 12) | (32'(oi) << 4) | 32'(kd);
            req_valid = 1'b1;
            ef = ref_fault(req_offset, req_len_m1, desc_limit, g[0], ed[0], bg[0],
                           cd[0], wr[0], pr[0], st[0], kd[1:0]);
            begin
                logic [31:0] exp_addr;
                exp_addr = desc_base + req_offset;
                @(negedge clk);
                check("R2 strobe after request", rsp_valid, 1);
                check("R3/R4/R5/R6/R7/R8/R9 fault code", rsp_fault, ef);
                if (ef == 2'b00) check("R1 linear address", lin_addr, exp_addr);
            end
        end

        req_valid = 1'b0;
        @(negedge clk);
        check("R2 idle strobe", rsp_valid, 0);
        check("R2 idle fault code", rsp_fault, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule